// File: doc/BRIEF.md
# NAND Bus Width Access Adapter

This block sits between a host register port and the I/O bus of NAND flash devices hung off a set of chip-selects. A host access of one, two or four bytes aimed at a chip-select's command, address or data window becomes a sequence of device cycles. The device bus is either 8 or 16 bits wide, chosen per chip-select. Writes split the host word into byte or halfword cycles, lowest lane first. Reads run one device cycle per lane and pack the results little-endian into one host word.

Each device cycle is offered on a valid/ready handshake. During the whole sequence the adapter holds the chip-enable of the target chip-select, together with the latch strobe that matches the window: command latch for the command window, address latch for the address window, neither for data. The host sees one acknowledge pulse, carrying read data and a width-error flag, once the final device cycle has been taken. Chip-selects not marked as NAND produce no device traffic. Accesses to the remaining register window also produce none, and there only full-word accesses are legal.

Top module: `nand_bus_adapter`

## Requirements
- R1: For a chip-select with an 8-bit bus (cs_wide_map bit 0), a write issues one cycle per host byte (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The cycles run from bits 7:0 upward, and each carries the byte on dev_wdata[7:0] with bits 15:8 zero.
- R2: For a chip-select with a 16-bit bus (cs_wide_map bit 1), a 4-byte write issues two cycles, bits 15:0 then bits 31:16. A 1-byte or 2-byte write issues one cycle carrying host_wdata[15:0].
- R3: On an 8-bit bus, a read performs one cycle per requested byte. Cycle k supplies dev_rdata[7:0] as byte k of host_rdata, and the unrequested bytes read zero.
- R4: On a 16-bit bus, a 4-byte read performs two cycles, with the first in bits 15:0. A 2-byte read performs one cycle and returns all 16 bits. A 1-byte read performs one cycle and returns only dev_rdata[7:0], zero-extended.
- R5: The window is host_addr[3:2]: 0 command, 1 address, 2 data, 3 other. Command writes raise dev_cle, address writes raise dev_ale, and data accesses raise neither. dev_we is high for writes and low for reads.
- R6: The chip-select index is host_addr[ADDR_W-1:4]. During a sequence exactly the matching dev_ce bit is high. dev_ce, dev_cle, dev_ale and dev_we stay constant across all of the sequence's cycles, and dev_wdata holds while dev_ready is low.
- R7: If the chip-select's cs_nand_map bit is 0, an access to the command, address or data window runs no device cycles, and a read returns zero.
- R8: A read of the command or address window runs no device cycles and returns zero.
- R9: An access to window 3 runs no device cycles and reads zero. host_err is set with the acknowledge when its size code is not 2, and is clear for every other access.
- R10: host_ack is a single-cycle pulse in the cycle after the final device handshake, or in the cycle after acceptance when no device cycles are needed. host_req_ready is low from acceptance until after the acknowledge.
- R11: Size code 3 behaves like code 2 (4 bytes) in the command, address and data windows.
- R12: After reset host_req_ready is high, while dev_valid, dev_ce and host_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Adapter can accept a request |
| host_addr | input | ADDR_W | Chip-select, window and byte offset |
| host_size | input | 2 | Access size code |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | Access complete pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_err | output | 1 | Illegal width, valid with host_ack |
| cs_nand_map | input | NUM_CS | Per chip-select: device is NAND |
| cs_wide_map | input | NUM_CS | Per chip-select: 16-bit device bus |
| dev_valid | output | 1 | Device cycle offered |
| dev_ready | input | 1 | Device takes the cycle |
| dev_ce | output | NUM_CS | Chip enables, active high |
| dev_cle | output | 1 | Command latch strobe |
| dev_ale | output | 1 | Address latch strobe |
| dev_we | output | 1 | Cycle direction, 1 = write |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, sampled on handshake |

## Verification
Every combination of bus width, size code and window is tried on both NAND and plain chip-selects. The outcomes separate the byte-lane slicing of the 8-bit bus from the halfword slicing of the 16-bit bus. They also separate the one-byte truncation on wide reads from a full halfword return, and the legal no-traffic cases (plain chip-select, read of a latch window, the other window) from real sequences. Random dev_ready stalls show whether strobes and data hold, and whether the acknowledge follows the true last handshake rather than a cycle count. Random data with distinct bytes shows whether a lane is misplaced or duplicated.

// File: rtl/nba_pkg.sv
package nba_pkg;
  localparam int HOST_W = 32;
  localparam int DEV_W  = 16;
  localparam int CYC_W  = 3;

  typedef enum logic [1:0] {
    WIN_CMD   = 2'd0,
    WIN_ADDR  = 2'd1,
    WIN_DATA  = 2'd2,
    WIN_OTHER = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  typedef struct packed {
    logic             cle;
    logic             ale;
    logic             wide;
    logic             err;
    logic [CYC_W-1:0] ncyc;
  } plan_t;
endpackage

// File: rtl/nba_decode.sv
module nba_decode
  import nba_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3,
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              we,
  input  logic [NUM_CS-1:0] nand_map,
  input  logic [NUM_CS-1:0] wide_map,
  output logic [CS_W-1:0]   cs,
  output plan_t             plan
);
  win_e       win;
  logic       is_nand;
  logic       go;
  logic [2:0] nbytes;

  always_comb begin
    win     = win_e'(addr[3:2]);
    cs      = addr[ADDR_W-1:4];
    is_nand = nand_map[cs];
    plan    = '0;
    plan.wide = wide_map[cs];
    case (size)
      2'd0:    nbytes = 3'd1;
      2'd1:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
    go = 1'b0;
    case (win)
      WIN_CMD:   begin go = is_nand && we; plan.cle = go; end
      WIN_ADDR:  begin go = is_nand && we; plan.ale = go; end
      WIN_DATA:  go = is_nand;
      default:   plan.err = (size != 2'd2);
    endcase
    if (go) begin
      if (plan.wide) plan.ncyc = (nbytes == 3'd4) ? CYC_W'(2) : CYC_W'(1);
      else           plan.ncyc = CYC_W'(nbytes);
    end
  end
endmodule

// File: rtl/nba_wr_lane.sv
module nba_wr_lane
  import nba_pkg::*;
(
  input  logic [HOST_W-1:0] wdata,
  input  logic [CYC_W-1:0]  idx,
  input  logic              wide,
  output logic [DEV_W-1:0]  lane
);
  always_comb begin
    if (wide) lane = idx[0] ? wdata[31:16] : wdata[15:0];
    else      lane = {8'h00, wdata[8*idx[1:0] +: 8]};
  end
endmodule

// File: rtl/nba_rd_pack.sv
module nba_rd_pack
  import nba_pkg::*;
(
  input  logic [HOST_W-1:0] acc,
  input  logic [CYC_W-1:0]  idx,
  input  logic              wide,
  input  logic [DEV_W-1:0]  rd,
  output logic [HOST_W-1:0] acc_nxt
);
  localparam int NB = HOST_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_nxt;
    always_comb begin
      byte_nxt = acc[8*b +: 8];
      if (wide) begin
        if (idx == CYC_W'(b / 2)) byte_nxt = rd[8*(b % 2) +: 8];
      end else if (idx == CYC_W'(b)) begin
        byte_nxt = rd[7:0];
      end
    end
    assign acc_nxt[8*b +: 8] = byte_nxt;
  end
endmodule

// File: rtl/nba_seq.sv
module nba_seq
  import nba_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  plan_t             plan,
  input  logic [CS_W-1:0]   cs,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [HOST_W-1:0] wdata,
  output logic              ack,
  output logic [HOST_W-1:0] rdata,
  output logic              err,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic [NUM_CS-1:0] dev_ce,
  output logic              dev_cle,
  output logic              dev_ale,
  output logic              dev_we,
  output logic [DEV_W-1:0]  dev_wdata,
  input  logic [DEV_W-1:0]  dev_rdata
);
  st_e               st;
  logic [CYC_W-1:0]  idx;
  logic [CYC_W-1:0]  ncyc_q;
  logic [HOST_W-1:0] wdata_q;
  logic [HOST_W-1:0] acc;
  logic [HOST_W-1:0] acc_nxt;
  logic              wide_q;
  logic              we_q;
  logic              byte1_q;
  logic              err_q;
  logic [HOST_W-1:0] lane_src;
  logic [CYC_W-1:0]  lane_idx;
  logic              lane_wide;
  logic [DEV_W-1:0]  lane;
  logic [NUM_CS-1:0] ce_sel;
  logic              accept;
  logic              last;

  assign accept = (st == ST_IDLE) && req_valid && req_ready;
  assign last   = (idx == CYC_W'(ncyc_q - CYC_W'(1)));

  always_comb begin
    ce_sel     = '0;
    ce_sel[cs] = 1'b1;
    if (st == ST_IDLE) begin
      lane_src  = wdata;
      lane_idx  = '0;
      lane_wide = plan.wide;
    end else begin
      lane_src  = wdata_q;
      lane_idx  = idx + CYC_W'(1);
      lane_wide = wide_q;
    end
  end

  nba_wr_lane u_wr_lane (
    .wdata (lane_src),
    .idx   (lane_idx),
    .wide  (lane_wide),
    .lane  (lane)
  );

  nba_rd_pack u_rd_pack (
    .acc     (acc),
    .idx     (idx),
    .wide    (wide_q),
    .rd      (dev_rdata),
    .acc_nxt (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_ready <= 1'b1;
      idx       <= '0;
      ncyc_q    <= '0;
      wdata_q   <= '0;
      acc       <= '0;
      wide_q    <= 1'b0;
      we_q      <= 1'b0;
      byte1_q   <= 1'b0;
      err_q     <= 1'b0;
      ack       <= 1'b0;
      rdata     <= '0;
      err       <= 1'b0;
      dev_valid <= 1'b0;
      dev_ce    <= '0;
      dev_cle   <= 1'b0;
      dev_ale   <= 1'b0;
      dev_we    <= 1'b0;
      dev_wdata <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            req_ready <= 1'b0;
            wdata_q   <= wdata;
            wide_q    <= plan.wide;
            ncyc_q    <= plan.ncyc;
            we_q      <= we;
            byte1_q   <= (size == 2'd0);
            err_q     <= plan.err;
            acc       <= '0;
            idx       <= '0;
            if (plan.ncyc != '0) begin
              st        <= ST_RUN;
              dev_valid <= 1'b1;
              dev_we    <= we;
              dev_cle   <= plan.cle;
              dev_ale   <= plan.ale;
              dev_ce    <= ce_sel;
              dev_wdata <= we ? lane : '0;
            end else begin
              st    <= ST_DONE;
              ack   <= 1'b1;
              rdata <= '0;
              err   <= plan.err;
            end
          end
        end
        ST_RUN: begin
          if (dev_ready) begin
            acc <= acc_nxt;
            if (last) begin
              st        <= ST_DONE;
              dev_valid <= 1'b0;
              dev_ce    <= '0;
              dev_cle   <= 1'b0;
              dev_ale   <= 1'b0;
              dev_we    <= 1'b0;
              dev_wdata <= '0;
              ack       <= 1'b1;
              err       <= err_q;
              if (we_q)         rdata <= '0;
              else if (byte1_q) rdata <= {24'h0, acc_nxt[7:0]};
              else              rdata <= acc_nxt;
            end else begin
              idx       <= idx + CYC_W'(1);
              dev_wdata <= we_q ? lane : '0;
            end
          end
        end
        default: begin
          st        <= ST_IDLE;
          req_ready <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_bus_adapter.sv
module nand_bus_adapter
  import nba_pkg::*;
#(
  parameter  int NUM_CS = 8,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int ADDR_W = CS_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic              host_we,
  input  logic [31:0]       host_wdata,
  output logic              host_ack,
  output logic [31:0]       host_rdata,
  output logic              host_err,
  input  logic [NUM_CS-1:0] cs_nand_map,
  input  logic [NUM_CS-1:0] cs_wide_map,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic [NUM_CS-1:0] dev_ce,
  output logic              dev_cle,
  output logic              dev_ale,
  output logic              dev_we,
  output logic [15:0]       dev_wdata,
  input  logic [15:0]       dev_rdata
);
  plan_t           plan;
  logic [CS_W-1:0] cs;

  nba_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W)) u_decode (
    .addr     (host_addr),
    .size     (host_size),
    .we       (host_we),
    .nand_map (cs_nand_map),
    .wide_map (cs_wide_map),
    .cs       (cs),
    .plan     (plan)
  );

  nba_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (host_req_valid),
    .req_ready (host_req_ready),
    .plan      (plan),
    .cs        (cs),
    .we        (host_we),
    .size      (host_size),
    .wdata     (host_wdata),
    .ack       (host_ack),
    .rdata     (host_rdata),
    .err       (host_err),
    .dev_valid (dev_valid),
    .dev_ready (dev_ready),
    .dev_ce    (dev_ce),
    .dev_cle   (dev_cle),
    .dev_ale   (dev_ale),
    .dev_we    (dev_we),
    .dev_wdata (dev_wdata),
    .dev_rdata (dev_rdata)
  );
endmodule

// File: rtl/nba_chk.sv
module nba_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_req_ready,
  input logic              host_ack,
  input logic              dev_valid,
  input logic              dev_ready,
  input logic [NUM_CS-1:0] dev_ce,
  input logic              dev_cle,
  input logic              dev_ale,
  input logic              dev_we,
  input logic [15:0]       dev_wdata
);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    host_req_ready |-> (!dev_valid && dev_ce == '0));

  // R6
  ce_single_chk: assert property (@(posedge clk) disable iff (rst)
    dev_valid |-> ($countones(dev_ce) == 1));

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_wdata) && $stable(dev_ce)));

  // R6
  strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
    dev_valid |=> (!dev_valid || ($stable(dev_ce) && $stable(dev_cle) && $stable(dev_ale) && $stable(dev_we))));

  // R5
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && (dev_cle || dev_ale)) |-> (dev_we && !(dev_cle && dev_ale)));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> (!host_ack && host_req_ready));

  // R10
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
    dev_valid |-> (!host_ack && !host_req_ready));
endmodule

bind nand_bus_adapter nba_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .host_req_ready (host_req_ready),
  .host_ack       (host_ack),
  .dev_valid      (dev_valid),
  .dev_ready      (dev_ready),
  .dev_ce         (dev_ce),
  .dev_cle        (dev_cle),
  .dev_ale        (dev_ale),
  .dev_we         (dev_we),
  .dev_wdata      (dev_wdata)
);

// File: tb/nand_bus_adapter_tb_top.sv
module nand_bus_adapter_tb_top;
  localparam int NUM_CS = 8;
  localparam int ADDR_W = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_req_valid = 1'b0;
  logic              host_req_ready;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [1:0]        host_size = '0;
  logic              host_we = 1'b0;
  logic [31:0]       host_wdata = '0;
  logic              host_ack;
  logic [31:0]       host_rdata;
  logic              host_err;
  logic [NUM_CS-1:0] cs_nand_map = 8'b1111_1110;
  logic [NUM_CS-1:0] cs_wide_map = 8'b1010_1010;
  logic              dev_valid;
  logic              dev_ready = 1'b0;
  logic [NUM_CS-1:0] dev_ce;
  logic              dev_cle;
  logic              dev_ale;
  logic              dev_we;
  logic [15:0]       dev_wdata;
  logic [15:0]       dev_rdata = '0;

  int checks = 0;
  int errors = 0;
  int tick = 0;

  logic [15:0]       lg_wd [8];
  logic [15:0]       lg_rd [8];
  logic              lg_cle [8];
  logic              lg_ale [8];
  logic              lg_we [8];
  logic [NUM_CS-1:0] lg_ce [8];
  int                lg_tick [8];
  int                nlog = 0;

  nand_bus_adapter #(.NUM_CS(NUM_CS)) dut_i (.*);

  always #2 clk = ~clk;

  always @(posedge clk) tick <= tick + 1;

  // device model: decide ready and read data at the falling edge, log transfers
  always @(negedge clk) begin
    dev_ready = ($urandom % 4) != 0;
    dev_rdata = 16'($urandom);
    if (dev_valid && dev_ready && !rst && nlog < 8) begin
      lg_wd[nlog]   = dev_wdata;
      lg_rd[nlog]   = dev_rdata;
      lg_cle[nlog]  = dev_cle;
      lg_ale[nlog]  = dev_ale;
      lg_we[nlog]   = dev_we;
      lg_ce[nlog]   = dev_ce;
      lg_tick[nlog] = tick;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_ncyc(int cs, int win, int sz, bit we);
    bit go;
    int nb;
    go = cs_nand_map[cs] && (win == 2 || (win < 2 && we));
    if (!go) return 0;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (cs_wide_map[cs]) return (nb == 4) ? 2 : 1;
    return nb;
  endfunction

  function automatic logic [15:0] exp_lane(bit wide, int k, logic [31:0] wd);
    if (wide) return wd[16*k +: 16];
    return {8'h00, wd[8*k +: 8]};
  endfunction

  function automatic string req_tag(int cs, int win, int sz, bit we);
    if (win == 3) return "R9";
    if (!cs_nand_map[cs]) return "R7";
    if (!we && win < 2) return "R8";
    if (sz == 3) return "R11";
    if (cs_wide_map[cs]) return we ? "R2" : "R4";
    return we ? "R1" : "R3";
  endfunction

  task automatic access(input int cs, input int win, input int sz, input bit we,
                        input logic [31:0] wd);
    int n;
    int guard;
    int ack_tick;
    bit wide;
    string tg;
    logic [31:0] exp_rd;
    n = exp_ncyc(cs, win, sz, we);
    wide = cs_wide_map[cs];
    tg = req_tag(cs, win, sz, we);
    @(negedge clk);
    guard = 0;
    while (!host_req_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    nlog = 0;
    host_req_valid = 1'b1;
    host_addr  = {cs[2:0], win[1:0], 2'($urandom)};
    host_size  = sz[1:0];
    host_we    = we;
    host_wdata = wd;
    @(negedge clk);
    host_req_valid = 1'b0;
    guard = 0;
    while (!host_ack && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    ack_tick = tick;
    check(host_ack, "R10", "ack seen", 32'(host_ack), 1);
    check(nlog == n, tg, "cycle count", 32'(nlog), 32'(n));
    // R10: no ready while the acknowledge is up, ack one cycle after last handshake
    check(!host_req_ready, "R10", "ready low at ack", 32'(host_req_ready), 0);
    if (n > 0 && nlog == n)
      check(ack_tick == lg_tick[n-1] + 1, "R10", "ack timing", 32'(ack_tick), 32'(lg_tick[n-1] + 1));
    check(host_err == (win == 3 && sz != 2), "R9", "err flag", 32'(host_err), 32'(win == 3 && sz != 2));
    exp_rd = '0;
    for (int k = 0; k < n && k < nlog; k++) begin
      if (we) check(lg_wd[k] == exp_lane(wide, k, wd), tg, "write lane", 32'(lg_wd[k]), 32'(exp_lane(wide, k, wd)));
      check(lg_cle[k] == (win == 0) && lg_ale[k] == (win == 1) && lg_we[k] == we,
            "R5", "strobes", {29'h0, lg_cle[k], lg_ale[k], lg_we[k]},
            {29'h0, win == 0, win == 1, we});
      check(lg_ce[k] == NUM_CS'(1 << cs), "R6", "chip enable", 32'(lg_ce[k]), 32'(1 << cs));
      if (wide) exp_rd[16*k +: 16] = lg_rd[k];
      else      exp_rd[8*k +: 8] = lg_rd[k][7:0];
    end
    if (we || n == 0) exp_rd = '0;
    if (sz == 0) exp_rd = exp_rd & 32'hff;
    if (!we) check(host_rdata == exp_rd, tg, "read data", host_rdata, exp_rd);
    @(negedge clk);
    check(!host_ack && host_req_ready, "R10", "single ack pulse", {30'h0, host_ack, host_req_ready}, 32'h1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    // R12 reset state
    check(host_req_ready && !dev_valid && !host_ack && dev_ce == '0, "R12", "reset state",
          {28'h0, host_req_ready, dev_valid, host_ack, |dev_ce}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    check(host_req_ready && !dev_valid, "R12", "after reset", {30'h0, host_req_ready, dev_valid}, 32'h2);

    access(2, 0, 2, 1, 32'hA1B2C3D4);   // R1 narrow cmd 4 bytes
    access(4, 1, 1, 1, 32'h11223344);   // R1 narrow address 2 bytes
    access(6, 2, 0, 1, 32'h55667788);   // R1 narrow data 1 byte
    access(1, 2, 2, 1, 32'hDEADBEEF);   // R2 wide 4 bytes
    access(3, 0, 0, 1, 32'h0000CAFE);   // R2 wide 1 byte passes halfword
    access(2, 2, 2, 0, 32'h0);          // R3 narrow read 4
    access(4, 2, 0, 0, 32'h0);          // R3 narrow read 1
    access(1, 2, 2, 0, 32'h0);          // R4 wide read 4
    access(5, 2, 1, 0, 32'h0);          // R4 wide read 2
    access(7, 2, 0, 0, 32'h0);          // R4 wide read 1 truncated
    access(0, 2, 2, 0, 32'h0);          // R7 non-NAND read
    access(0, 0, 2, 1, 32'h12345678);   // R7 non-NAND write
    access(2, 0, 2, 0, 32'h0);          // R8 read of command window
    access(3, 1, 1, 0, 32'h0);          // R8 read of address window
    access(2, 3, 1, 1, 32'h1);          // R9 other window, short
    access(2, 3, 2, 0, 32'h0);          // R9 other window, word
    access(2, 2, 3, 1, 32'h99AABBCC);   // R11 code 3 narrow
    access(1, 2, 3, 0, 32'h0);          // R11 code 3 wide

    for (int i = 0; i < 300; i++)
      access(int'($urandom % 8), int'($urandom % 4), int'($urandom % 4), 1'($urandom), $urandom);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (tick > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected below 150000", tick);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule